// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous static RAM. Its bus uses a request/data split. On one rising edge the block samples the address, the read/write select, the lane write selects and the chip enables. The data transfer for that request happens in the cycle that follows. Write data therefore arrives one cycle after its address. Because of this, a read request can be placed in the same cycle as the data phase of an earlier write, and the reverse also works, so the bus never needs an idle cycle to change direction.

The read path has no output register. During a read data cycle, `dout` follows the array word at the pending address combinationally. The shared bidirectional data bus is split into `din`, `dout` and a drive-enable `dout_en`. Three other inputs control the block: a clock enable that suspends all activity, an output enable that acts without the clock, and a sleep input that blocks new requests and keeps the array contents. Burst address generation is not part of this block. When the load input is high, no request is taken.

The control state machine has three phases. `ST_IDLE` means no transfer is in this cycle. `ST_RD` is the data cycle of a read. `ST_WR` is the data cycle of a write. The transitions are as follows. On every edge where the clock enable is active, the next phase comes from the request sampled on that edge: a valid read request goes to `ST_RD`, a valid write request goes to `ST_WR`, and anything else goes to `ST_IDLE`. This rule applies from any phase, including `ST_IDLE` to `ST_IDLE`, `ST_RD` to `ST_WR` and `ST_WR` to `ST_RD`. On an edge where the clock enable is inactive, the phase stays as it is. Reset places the machine in `ST_IDLE`.

Top module: `zbt_ft_sram`

## Requirements
- R1: A read request sampled on edge k makes `dout_en` high and `dout` equal to the stored word at that address in the cycle after edge k. No further clock edge is needed.
- R2: In the data cycle of a write, the value on `din` is written into the array on the edge that ends that cycle.
- R3: Read and write requests may be issued on consecutive edges with no idle cycle. A read requested on the edge that ends a write's data cycle, at the same address, returns the newly written word.
- R4: While `clk_en_n` is 1, all synchronous inputs are ignored. The phase, the pending address and the pending lane selects keep their values, so a pending read keeps driving and a pending write waits for the next enabled edge.
- R5: A request is accepted only when `load_n`=0, `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. In any other case the array is not changed. A transfer already pending still completes in its data cycle.
- R6: `dout_en` is low in the cycle after an enabled edge that sampled a deselect, an idle request or a write request.
- R7: `oe_n`=1 forces `dout_en` low at once, without waiting for a clock edge.
- R8: While `sleep`=1, no request is accepted and `dout_en` is low. Array contents are kept.
- R9: `lane_we_n[i]`=0 enables writing of lane i, which is `din[9*i+8:9*i]`. Lanes whose select is 1 keep their old contents. The lane selects are sampled together with the write request.
- R10: During and directly after reset, the phase is `ST_IDLE` and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| clk_en_n | input | 1 | Active-low clock enable; 1 suspends the block |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | 0 requests a new operation |
| rw_read | input | 1 | 1 = read request, 0 = write request |
| lane_we_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, valid in the write data cycle |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep; blocks requests and output |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_en | output | 1 | Drive enable for the shared bus |

## Verification
A wrong phase shows up at the ports in the very next cycle. `dout_en` rises where no read was requested, or it stays low under a pending read. A pending address or lane register that was captured wrongly, or that was not held during a suspension, shows up on the first read-back of that word, which is one cycle after the read request. Write-path faults, such as a wrong lane mask or a commit made while suspended, stay hidden until the word is read back. For that reason, each write scenario in the bench ends with a read of the affected address.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } phase_t;
endpackage

// File: rtl/zbt_req_decode.sv
module zbt_req_decode (
    input  logic load_n,
    input  logic sel_a_n,
    input  logic sel_b,
    input  logic sel_c_n,
    input  logic sleep,
    input  logic rw_read,
    output logic start_rd,
    output logic start_wr
);
    logic chip_on;
    logic accept;

    always_comb begin
        chip_on  = !sel_a_n && sel_b && !sel_c_n;
        accept   = chip_on && !load_n && !sleep;
        start_rd = accept && rw_read;
        start_wr = accept && !rw_read;
    end
endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_lane_n,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [LANES-1:0]  pend_lanes,
    output logic              rd_phase,
    output logic              wr_commit
);
    phase_t phase_q;
    phase_t phase_d;

    always_comb begin
        if (start_rd)      phase_d = ST_RD;
        else if (start_wr) phase_d = ST_WR;
        else               phase_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q    <= ST_IDLE;
            pend_addr  <= '0;
            pend_lanes <= '0;
        end else if (!clk_en_n) begin
            phase_q    <= phase_d;
            pend_addr  <= req_addr;
            pend_lanes <= ~req_lane_n;
        end
    end

    always_comb begin
        rd_phase  = 1'b0;
        wr_commit = 1'b0;
        unique case (phase_q)
            ST_IDLE: ;
            ST_RD:   rd_phase  = 1'b1;
            ST_WR:   wr_commit = !clk_en_n;
            default: ;
        endcase
    end

    // R4
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(phase_q) && $stable(pend_addr) && $stable(pend_lanes));

    // R5
    no_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !start_rd && !start_wr) |=> phase_q == ST_IDLE);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> phase_q == ST_IDLE);
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [LANES-1:0]              lane_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [LANES-1:0][LANE_W-1:0]  wdata,
    output logic [LANES-1:0][LANE_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en && lane_en[g]) mem[addr][g] <= wdata[g];
        end

        // R9
        lane_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && lane_en[g]) |=> mem[$past(addr)][g] == $past(wdata[g]));
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clk_en_n,
    input  logic                      sel_a_n,
    input  logic                      sel_b,
    input  logic                      sel_c_n,
    input  logic                      load_n,
    input  logic                      rw_read,
    input  logic [LANES-1:0]          lane_we_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   din,
    input  logic                      oe_n,
    input  logic                      sleep,
    output logic [LANES*LANE_W-1:0]   dout,
    output logic                      dout_en
);
    logic                         start_rd;
    logic                         start_wr;
    logic [ADDR_W-1:0]            pend_addr;
    logic [LANES-1:0]             pend_lanes;
    logic                         rd_phase;
    logic                         wr_commit;
    logic [LANES-1:0][LANE_W-1:0] rdata;

    zbt_req_decode u_dec (
        .load_n  (load_n),
        .sel_a_n (sel_a_n),
        .sel_b   (sel_b),
        .sel_c_n (sel_c_n),
        .sleep   (sleep),
        .rw_read (rw_read),
        .start_rd(start_rd),
        .start_wr(start_wr)
    );

    zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .req_addr  (addr),
        .req_lane_n(lane_we_n),
        .pend_addr (pend_addr),
        .pend_lanes(pend_lanes),
        .rd_phase  (rd_phase),
        .wr_commit (wr_commit)
    );

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_commit),
        .lane_en(pend_lanes),
        .addr   (pend_addr),
        .wdata  (din),
        .rdata  (rdata)
    );

    assign dout    = rdata;
    assign dout_en = rd_phase && !oe_n && !sleep;

    // R6
    drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !start_rd) |=> !dout_en);

    // R8
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && sleep) |=> !dout_en);

    // R7
    always_comb begin
        oe_force_chk: assert (!(oe_n && dout_en));
    end
endmodule

// File: tb/tb_zbt_ft_sram.sv
module tb_zbt_ft_sram;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          sel_a_n = 1'b0;
    logic          sel_b = 1'b1;
    logic          sel_c_n = 1'b0;
    logic          load_n = 1'b1;
    logic          rw_read = 1'b1;
    logic [NL-1:0] lane_we_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [DW-1:0] D1 = 36'h1_2345_6789;
    localparam logic [DW-1:0] D2 = 36'hA_BCDE_F012;
    localparam logic [DW-1:0] DA = 36'h3_3333_3333;
    localparam logic [DW-1:0] DB = 36'hC_CCCC_CCCC;
    localparam logic [DW-1:0] X1 = 36'h5_A5A5_A5A5;
    localparam logic [DW-1:0] W11 = 36'h0_F0F0_F0F1;
    localparam logic [DW-1:0] GARB = 36'hF_FFFF_FFFF;

    always #4 clk = ~clk;

    zbt_ft_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .load_n(load_n), .rw_read(rw_read), .lane_we_n(lane_we_n),
        .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // set request and data for one cycle, return at the next falling edge
    task automatic step(input logic ld_n, input logic rd, input int a,
                        input logic [NL-1:0] ben, input logic [DW-1:0] d);
        load_n    = ld_n;
        rw_read   = rd;
        addr      = AW'(a);
        lane_we_n = ben;
        din       = d;
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [NL-1:0] ben);
        logic [DW-1:0] r;
        for (int i = 0; i < NL; i++)
            r[i*LW +: LW] = ben[i] ? old_w[i*LW +: LW] : new_w[i*LW +: LW];
        return r;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(dout_en == 1'b0, "R10 in reset", DW'(dout_en), '0);
        rst_n = 1'b1;
        step(1, 1, 0, '1, '0);
        check(dout_en == 1'b0, "R10 after reset", DW'(dout_en), '0);
    endtask

    task automatic t_write_read();
        step(0, 0, 5, '0, '0);
        check(dout_en == 1'b0, "R6 write data cycle", DW'(dout_en), '0);
        step(0, 1, 5, '1, D1);
        check(dout_en == 1'b1, "R1 read enable", DW'(dout_en), 1);
        check(dout == D1, "R3 read after write", dout, D1);
        step(0, 0, 5, '0, '0);
        check(dout_en == 1'b0, "R6 read to write", DW'(dout_en), '0);
        step(0, 1, 5, '1, D2);
        check(dout == D2, "R2 second write", dout, D2);
        step(1, 1, 0, '1, '0);
        check(dout_en == 1'b0, "R6 idle after read", DW'(dout_en), '0);
    endtask

    task automatic t_lanes();
        step(0, 0, 7, '0, '0);
        step(1, 1, 0, '1, DA);
        step(0, 0, 7, 4'b1010, '0);
        step(0, 1, 7, '1, DB);
        check(dout == merge(DA, DB, 4'b1010), "R9 lane mask", dout, merge(DA, DB, 4'b1010));
        step(1, 1, 0, '1, '0);
    endtask

    task automatic t_deselect();
        step(0, 0, 9, '0, '0);
        step(0, 1, 9, '1, X1);
        check(dout == X1, "R5 preset word", dout, X1);
        sel_b = 1'b0;
        #1;
        check(dout_en == 1'b1, "R5 pending read completes", DW'(dout_en), 1);
        step(0, 0, 9, '0, '0);
        check(dout_en == 1'b0, "R6 after deselect", DW'(dout_en), '0);
        sel_b = 1'b1;
        step(1, 1, 0, '1, GARB);
        sel_a_n = 1'b1;
        step(0, 0, 9, '0, '0);
        sel_a_n = 1'b0;
        step(1, 1, 0, '1, GARB);
        sel_c_n = 1'b1;
        step(0, 0, 9, '0, '0);
        sel_c_n = 1'b0;
        step(1, 1, 0, '1, GARB);
        step(1, 0, 9, '0, '0);
        step(1, 1, 0, '1, GARB);
        step(0, 1, 9, '1, '0);
        check(dout == X1, "R5 no write when deselected or load high", dout, X1);
        step(1, 1, 0, '1, '0);
    endtask

    task automatic t_clken();
        step(0, 1, 5, '1, '0);
        clk_en_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 5, '0, GARB);
            check(dout_en == 1'b1 && dout == D2, "R4 read held", dout, D2);
        end
        clk_en_n = 1'b0;
        step(1, 1, 0, '1, '0);
        check(dout_en == 1'b0, "R4 resumes idle", DW'(dout_en), '0);
        step(0, 0, 11, '0, '0);
        clk_en_n = 1'b1;
        step(1, 1, 0, '1, GARB);
        step(1, 1, 0, '1, GARB);
        clk_en_n = 1'b0;
        step(1, 1, 0, '1, W11);
        step(0, 1, 11, '1, '0);
        check(dout == W11, "R4 write waits for enabled edge", dout, W11);
        step(0, 1, 5, '1, '0);
        check(dout == D2, "R4 suspended write ignored", dout, D2);
        step(1, 1, 0, '1, '0);
    endtask

    task automatic t_oe();
        step(0, 1, 5, '1, '0);
        oe_n = 1'b1;
        #1;
        check(dout_en == 1'b0, "R7 forced off", DW'(dout_en), '0);
        oe_n = 1'b0;
        #1;
        check(dout_en == 1'b1, "R7 released", DW'(dout_en), 1);
        step(1, 1, 0, '1, '0);
    endtask

    task automatic t_sleep();
        step(0, 1, 7, '1, '0);
        sleep = 1'b1;
        #1;
        check(dout_en == 1'b0, "R8 output off in sleep", DW'(dout_en), '0);
        step(0, 0, 7, '0, '0);
        step(0, 1, 7, '1, GARB);
        sleep = 1'b0;
        step(1, 1, 0, '1, GARB);
        #1;
        check(dout_en == 1'b0, "R8 request blocked", DW'(dout_en), '0);
        step(0, 1, 7, '1, '0);
        check(dout == merge(DA, DB, 4'b1010), "R8 contents kept", dout, merge(DA, DB, 4'b1010));
        step(1, 1, 0, '1, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write_read();
        t_lanes();
        t_deselect();
        t_clken();
        t_oe();
        t_sleep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule